// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block holds the status byte of a serial nonvolatile memory and decides, for every write the memory's command front end wants to perform, whether that write may go ahead. It keeps a hardware-lock enable bit, a two-bit protection level, the write-enable latch and a busy flag. It also runs a fixed-length internal write cycle, during which the memory accepts nothing but status reads.

The front end drives one-cycle pulses into the block: latch set, latch clear, status write (with its data byte, presented when chip select rises), and data write. Each address is checked on a separate port. A low-active guard pin can freeze the status register, but only once the hardware-lock enable bit has been set. The protection level fences off the upper quarter, the upper half or the whole of the array. The boundaries are derived from the address width.

Top module: `blockguard_status`

## Requirements
- R1: After reset the status byte reads 0x00, and `addr_ok` and `cycle_start` are 0.
- R2: When idle, the status byte is {lock_en, 3'b000, lvl[1], lvl[0], latch, busy}: bit 7 is the lock enable, bits 3:2 are the protection level, bit 1 is the write-enable latch, bit 0 is busy, and bits 6:4 read 0.
- R3: While an internal write cycle runs, the status byte reads 0xFF.
- R4: When idle, a `latch_set` pulse sets the latch and a `latch_clr` pulse clears it whatever `guard_n` is. If both arrive in the same cycle, the clear wins.
- R5: A status write is accepted only when the latch is set, no cycle is running and the hardware lock is off. It changes only bits 7, 3 and 2. The latch and busy bits do not come from the write data.
- R6: The hardware lock is on exactly when `guard_n` is 0 and the lock enable is 1. A status write under the lock is dropped, so the lock enable stays 1 for as long as `guard_n` stays low. With the lock enable at 0, `guard_n` has no effect.
- R7: With A = 2^ADDR_W, level 0 protects no address, level 1 protects addresses at or above 3A/4, level 2 protects those at or above A/2, and level 3 protects all of them. `addr_ok` is 1 only for an unprotected address while the latch is set and no cycle runs. `guard_n` does not affect it.
- R8: An accepted write pulses `cycle_start` in the cycle it is presented. Busy then holds for exactly WRITE_CYCLES cycles. When it ends, the latch is clear.
- R9: While busy, `latch_set`, `latch_clr`, status writes and data writes have no effect.
- R10: A data write to an address for which `addr_ok` is 0 starts no cycle and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| guard_n | input | 1 | External write-guard pin, active low |
| latch_set | input | 1 | Write-enable command pulse |
| latch_clr | input | 1 | Write-disable command pulse |
| stat_wr | input | 1 | Status write pulse, issued at chip-select release |
| stat_wdata | input | 8 | Status write data |
| data_wr | input | 1 | Array write pulse for `chk_addr` |
| chk_addr | input | ADDR_W | Address under check |
| stat_rdata | output | 8 | Status byte |
| addr_ok | output | 1 | A data write to `chk_addr` is permitted now |
| cycle_start | output | 1 | An accepted write starts the internal cycle |

## Verification
The hardest state to reach is the lock enable at 1 while the guard pin is low. Only an unlocked status write can set that bit, and no status write can clear it while the pin stays low. The stimulus therefore sets the bit with the pin high, pulls the pin low, and shows that a clearing write is dropped with the latch still set. It then raises the pin and shows that the same write now succeeds. A sweep over every address at each of the four protection levels compares `addr_ok` with a boundary computed arithmetically.

// File: rtl/blockguard_pkg.sv
package blockguard_pkg;
  typedef logic [1:0] prot_lvl_t;

  localparam int LOCK_BIT  = 7;
  localparam int LVL_HI    = 3;
  localparam int LVL_LO    = 2;
  localparam int LATCH_BIT = 1;
  localparam int BUSY_BIT  = 0;

  function automatic logic [7:0] pack_status(input logic lock_en, input prot_lvl_t lvl,
                                             input logic latch, input logic busy);
    logic [7:0] s;
    s = 8'h00;
    if (busy) begin
      s = 8'hFF;
    end else begin
      s[LOCK_BIT]      = lock_en;
      s[LVL_HI:LVL_LO] = lvl;
      s[LATCH_BIT]     = latch;
    end
    return s;
  endfunction
endpackage

// File: rtl/blockguard_region.sv
module blockguard_region #(
  parameter int ADDR_W = 6
) (
  input  logic [1:0]        lvl,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  function automatic logic zone_hit(input logic [1:0] l, input logic [ADDR_W-1:0] a);
    case (l)
      2'd0:    return 1'b0;
      2'd1:    return &a[ADDR_W-1:ADDR_W-2];
      2'd2:    return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  assign hit = zone_hit(lvl, addr);
endmodule

// File: rtl/blockguard_timer.sv
module blockguard_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/blockguard_status.sv
module blockguard_status #(
  parameter int ADDR_W       = 6,
  parameter int WRITE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_n,
  input  logic              latch_set,
  input  logic              latch_clr,
  input  logic              stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              data_wr,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        stat_rdata,
  output logic              addr_ok,
  output logic              cycle_start
);
  import blockguard_pkg::*;

  logic      lock_en;
  prot_lvl_t lvl;
  logic      latch;
  logic      busy;
  logic      cyc_done;
  logic      zone_hit;
  logic      hw_lock;
  logic      stat_go;
  logic      data_go;

  blockguard_region #(.ADDR_W(ADDR_W)) u_region (
    .lvl  (lvl),
    .addr (chk_addr),
    .hit  (zone_hit)
  );

  blockguard_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cycle_start),
    .busy  (busy),
    .done  (cyc_done)
  );

  assign hw_lock     = !guard_n && lock_en;
  assign stat_go     = stat_wr && latch && !busy && !hw_lock;
  assign addr_ok     = latch && !busy && !zone_hit;
  assign data_go     = data_wr && addr_ok;
  assign cycle_start = stat_go || data_go;
  assign stat_rdata  = pack_status(lock_en, lvl, latch, busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_en <= 1'b0;
      lvl     <= '0;
    end else if (stat_go) begin
      lock_en <= stat_wdata[LOCK_BIT];
      lvl     <= stat_wdata[LVL_HI:LVL_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= 1'b0;
    end else if (cyc_done) begin
      latch <= 1'b0;
    end else if (!busy) begin
      if (latch_clr)      latch <= 1'b0;
      else if (latch_set) latch <= 1'b1;
    end
  end
endmodule

// File: rtl/blockguard_status_sva.sv
module blockguard_status_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       guard_n,
  input logic       latch_clr,
  input logic       stat_wr,
  input logic [7:0] stat_rdata,
  input logic       addr_ok,
  input logic       cycle_start,
  input logic       busy,
  input logic       latch,
  input logic       lock_en
);
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (stat_rdata[6:4] == 3'b000));

  assert_busy_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (stat_rdata == 8'hFF));

  assert_clear_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_clr && !busy) |=> !latch);

  assert_lock_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !guard_n && lock_en) |-> !cycle_start);

  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && !guard_n) |=> (lock_en || $past(busy)));

  assert_ok_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ok |-> (latch && !busy));

  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> busy);

  assert_end_unlatched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !latch);

  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cycle_start);
endmodule

bind blockguard_status blockguard_status_sva u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .guard_n     (guard_n),
  .latch_clr   (latch_clr),
  .stat_wr     (stat_wr),
  .stat_rdata  (stat_rdata),
  .addr_ok     (addr_ok),
  .cycle_start (cycle_start),
  .busy        (busy),
  .latch       (latch),
  .lock_en     (lock_en)
);

// File: tb/blockguard_status_test.sv
`timescale 1ns/1ps
module blockguard_status_test;
  localparam int AW = 6;
  localparam int WC = 4;
  localparam int A  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          guard_n = 1'b1;
  logic          latch_set = 1'b0;
  logic          latch_clr = 1'b0;
  logic          stat_wr = 1'b0;
  logic [7:0]    stat_wdata = 8'h00;
  logic          data_wr = 1'b0;
  logic [AW-1:0] chk_addr = '0;
  logic [7:0]    stat_rdata;
  logic          addr_ok;
  logic          cycle_start;

  int checks = 0;
  int errors = 0;
  logic cs_seen;
  bit done = 1'b0;

  always #4 clk = ~clk;

  blockguard_status #(.ADDR_W(AW), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .guard_n(guard_n), .latch_set(latch_set),
    .latch_clr(latch_clr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .data_wr(data_wr), .chk_addr(chk_addr), .stat_rdata(stat_rdata),
    .addr_ok(addr_ok), .cycle_start(cycle_start)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic apply(input logic ls, input logic lc, input logic sw,
                       input logic [7:0] wd, input logic dw, input logic [AW-1:0] ad);
    @(negedge clk);
    latch_set = ls; latch_clr = lc; stat_wr = sw; stat_wdata = wd;
    data_wr = dw; chk_addr = ad;
    #1 cs_seen = cycle_start;
    @(posedge clk); #1;
    latch_set = 1'b0; latch_clr = 1'b0; stat_wr = 1'b0; data_wr = 1'b0;
  endtask

  task automatic wait_cycle();
    for (int i = 0; i < WC; i++) tick();
  endtask

  task automatic write_status(input logic [7:0] d);
    apply(1, 0, 0, 8'h00, 0, '0);
    apply(0, 0, 1, d, 0, '0);
    wait_cycle();
  endtask

  function automatic int lowest_locked(input int lvl);
    case (lvl)
      0: return A;
      1: return (3 * A) / 4;
      2: return A / 2;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 status", stat_rdata, 8'h00);
    check("R1 addr_ok", addr_ok, 1'b0);
    check("R1 cycle_start", cycle_start, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    tick();

    // R4 / R2: latch set and clear
    apply(1, 0, 0, 8'h00, 0, '0);
    check("R4 set latch", stat_rdata, 8'h02);
    apply(0, 1, 0, 8'h00, 0, '0);
    check("R4 clear latch", stat_rdata, 8'h00);
    apply(1, 1, 0, 8'h00, 0, '0);
    check("R4 clear wins", stat_rdata, 8'h00);
    apply(1, 0, 0, 8'h00, 0, '0);
    guard_n = 1'b0;
    apply(0, 1, 0, 8'h00, 0, '0);
    check("R4 clear with guard low", stat_rdata, 8'h00);
    guard_n = 1'b1;

    // R5 without latch: dropped
    apply(0, 0, 1, 8'hFF, 0, '0);
    check("R5 no latch start", cs_seen, 1'b0);
    check("R5 no latch status", stat_rdata, 8'h00);

    // R5 / R8 / R3 / R9 accepted status write
    apply(1, 0, 0, 8'h00, 0, '0);
    apply(0, 0, 1, 8'hFF, 0, '0);
    check("R8 start pulse", cs_seen, 1'b1);
    check("R3 busy reads ones", stat_rdata, 8'hFF);
    apply(1, 0, 0, 8'h00, 0, '0);
    check("R3 busy still", stat_rdata, 8'hFF);
    apply(0, 0, 1, 8'h00, 1, '0);
    check("R9 write while busy", cs_seen, 1'b0);
    tick();
    check("R8 busy length", stat_rdata, 8'hFF);
    tick();
    check("R5 R8 R9 after cycle", stat_rdata, 8'h8C);

    // R6 hardware lock
    apply(1, 0, 0, 8'h00, 0, '0);
    guard_n = 1'b0;
    apply(0, 0, 1, 8'h00, 0, '0);
    check("R6 locked write dropped", cs_seen, 1'b0);
    check("R6 lock enable kept", stat_rdata, 8'h8E);
    guard_n = 1'b1;
    apply(0, 0, 1, 8'h00, 0, '0);
    check("R6 unlocked write", cs_seen, 1'b1);
    wait_cycle();
    check("R6 cleared", stat_rdata, 8'h00);
    guard_n = 1'b0;
    write_status(8'h04);
    check("R6 guard ignored when disabled", stat_rdata, 8'h04);
    guard_n = 1'b1;

    // R7 sweep
    for (int lv = 0; lv < 4; lv++) begin
      write_status(8'(lv << 2));
      check("R7 level set", stat_rdata, 8'(lv << 2));
      for (int a = 0; a < A; a++) begin
        @(negedge clk) chk_addr = AW'(a); #1;
        check("R7 no latch", addr_ok, 1'b0);
      end
      apply(1, 0, 0, 8'h00, 0, '0);
      for (int g = 0; g < 2; g++) begin
        guard_n = g[0];
        for (int a = 0; a < A; a++) begin
          @(negedge clk) chk_addr = AW'(a); #1;
          check("R7 region", addr_ok, (a < lowest_locked(lv)) ? 1'b1 : 1'b0);
        end
      end
      guard_n = 1'b1;
      apply(0, 1, 0, 8'h00, 0, '0);
    end

    // R10 data writes at level 2
    write_status(8'h08);
    apply(1, 0, 0, 8'h00, 0, '0);
    apply(0, 0, 0, 8'h00, 1, AW'(A - 24));
    check("R10 protected no start", cs_seen, 1'b0);
    check("R10 latch kept", stat_rdata, 8'h0A);
    apply(0, 0, 0, 8'h00, 1, AW'(5));
    check("R8 data start", cs_seen, 1'b1);
    check("R3 data busy", stat_rdata, 8'hFF);
    wait_cycle();
    check("R8 latch cleared after data", stat_rdata, 8'h08);

    // R7 guard does not block unprotected data with lock on
    write_status(8'h84);
    apply(1, 0, 0, 8'h00, 0, '0);
    guard_n = 1'b0;
    apply(0, 0, 0, 8'h00, 1, AW'(10));
    check("R7 data under lock", cs_seen, 1'b1);
    wait_cycle();
    check("R7 final status", stat_rdata, 8'h84);
    guard_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule